// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block stores the state that a physical memory protection checker consults. It has sixteen one-byte entry configurations, sixteen entry address registers and a three-bit security control word. Control-register reads and writes arrive on a single request port: a kind selector, a register index, write data and a flag for 32-bit or 64-bit operation. The bank applies the lock, reserved-encoding and sticky-bit rules to each write and keeps or drops every configuration byte on its own merits. It puts the whole configuration and address arrays on flat output buses for the checker.

A single-cycle pulse marks every clock edge at which stored protection state actually changed. Downstream caches of permission results use it to invalidate themselves. Address-range decoding, the access check and the legality of the control-register access itself are handled elsewhere.

Top module: `mpcfg_bank`

## Requirements
- R1: After reset every configuration byte, address register and security bit reads 0, and the change pulse is low.
- R2: Kind 0 accesses configuration registers. Byte i (bits 8i+7..8i) of configuration register n maps to entry 4n+i. There are 4 bytes when `csrIs64` is 0 and 8 bytes when it is 1. Bytes that map to entry 16 or above are ignored on write and read as 0.
- R3: A configuration byte holds R in bit 0, W in bit 1, X in bit 2, the match mode in bits 4:3 (1 = top-of-range) and the lock bit in bit 7. An entry is locked when its lock bit is set and the bypass bit (security bit 2) is clear. While bypass is set, no entry is locked.
- R4: With lockdown (security bit 0) clear, a configuration byte is dropped if its entry is locked, or if the new value has W=1 and R=0. The other bytes of the same write are still applied.
- R5: With lockdown set, a configuration byte is accepted when it has lock=1 and X=0, or lock=0 and an RWX field other than exactly W+X. Any other byte is accepted only while bypass is set.
- R6: Kind 1 writes address register n, keeping the low 32 data bits. The write is ignored when entry n is locked, or when entry n+1 has lock=1 and mode top-of-range.
- R7: Kind 2 writes the security word. The bypass bit is forced to 0 when it is currently 0 and any entry has its lock bit set.
- R8: Once set, lockdown (bit 0) and whitelist policy (bit 1) stay set until reset. Writing 0 to them has no effect.
- R9: When the bank is built with the enhanced-security parameter off, all three security bits stay 0 whatever is written.
- R10: The change pulse is high for exactly the cycle after a write that altered a stored configuration byte, an address register, lockdown or whitelist policy. It stays low otherwise, including after writes of unchanged values or of dropped bytes.
- R11: A write is visible on the outputs one clock after it is presented. Reads return current contents combinationally, so a read in the cycle of a write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csrWrEn | input | 1 | Write strobe for the current request |
| csrKind | input | 2 | 0 configuration, 1 address, 2 security, 3 none |
| csrIdx | input | 6 | Register index |
| csrWrData | input | 64 | Write data |
| csrIs64 | input | 1 | 1 selects 8 configuration bytes per register |
| csrRdData | output | 64 | Combinational read data for kind and index |
| cfgArray | output | 128 | All configuration bytes, entry e at bits 8e+7..8e |
| addrArray | output | 512 | All address registers, entry e at bits 32e+31..32e |
| secMml | output | 1 | Lockdown bit |
| secMmwp | output | 1 | Whitelist policy bit |
| secRlb | output | 1 | Lock bypass bit |
| protChanged | output | 1 | One-cycle pulse after any real state change |

## Verification
One configuration write can apply some of its bytes and drop others in the same cycle. This happens when one byte is W-only or targets a locked entry and a neighbouring byte carries a legal new value. The bench issues such mixed writes, both with lockdown clear and with lockdown set. It checks that only the legal bytes land, and that the change pulse follows whether any byte changed, not whether any byte was rejected. A behavioural model updates on every edge and is compared against all outputs on every clock, so mis-merged bytes or a wrong pulse show up in the cycle they occur.

// File: rtl/mpcfg_pkg.sv
package mpcfg_pkg;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_SEC  = 2'd2,
    KIND_NONE = 2'd3
  } csrKind_e;

  localparam int BIT_R = 0;
  localparam int BIT_W = 1;
  localparam int BIT_X = 2;
  localparam int BIT_L = 7;
  localparam logic [1:0] MODE_TOR = 2'd1;

  localparam int SEC_MML  = 0;
  localparam int SEC_MMWP = 1;
  localparam int SEC_RLB  = 2;

  typedef struct packed {
    logic       secLoad;
    logic [2:0] secNext;
    logic       changed;
  } ctrlStrobe_t;

endpackage

// File: rtl/mpcfg_ctrl.sv
module mpcfg_ctrl
  import mpcfg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int XLEN        = 64,
  parameter int IDX_W       = 6,
  parameter bit ENH_SEC     = 1'b1
) (
  input  logic                        csrWrEn,
  input  logic [1:0]                  csrKind,
  input  logic [IDX_W-1:0]            csrIdx,
  input  logic [XLEN-1:0]             csrWrData,
  input  logic                        csrIs64,
  input  logic [NUM_ENTRIES*8-1:0]    cfgArray,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] addrArray,
  input  logic [2:0]                  secBits,
  output logic [NUM_ENTRIES-1:0]      cfgLoad,
  output logic [NUM_ENTRIES*8-1:0]    cfgNext,
  output logic [NUM_ENTRIES-1:0]      addrLoad,
  output logic [ADDR_W-1:0]           addrNext,
  output ctrlStrobe_t                 strobe
);
  localparam int MAX_BYTES = XLEN / 8;
  localparam int SLOT_W    = $clog2(MAX_BYTES);

  csrKind_e kind;
  logic mml, mmwp, rlb;
  logic [NUM_ENTRIES-1:0] lockBit, lockedNow, torLockAbove;

  assign kind = csrKind_e'(csrKind);
  assign mml  = secBits[SEC_MML];
  assign mmwp = secBits[SEC_MMWP];
  assign rlb  = secBits[SEC_RLB];
  assign addrNext = csrWrData[ADDR_W-1:0];

  // Per-entry lock state and the top-of-range guard from the entry above
  always_comb begin
    torLockAbove = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      lockBit[e]   = cfgArray[e*8+BIT_L];
      lockedNow[e] = lockBit[e] & ~rlb;
    end
    for (int e = 0; e < NUM_ENTRIES-1; e++)
      torLockAbove[e] = cfgArray[(e+1)*8+BIT_L] &&
                        (cfgArray[(e+1)*8+3 +: 2] == MODE_TOR);
  end

  function automatic logic byteAccepted(input logic [7:0] nb, input logic lockedE,
                                        input logic mmlOn, input logic rlbOn);
    if (!mmlOn)
      return !lockedE && !(nb[BIT_W] && !nb[BIT_R]);
    return rlbOn || (nb[BIT_L] && !nb[BIT_X]) ||
           (!nb[BIT_L] && (nb[2:0] != 3'b110));
  endfunction

  always_comb begin
    int base, nBytes;
    logic [SLOT_W-1:0] slot;
    logic [7:0] newB;
    logic inWin;
    base   = int'(csrIdx) * 4;
    nBytes = (csrIs64 && MAX_BYTES >= 8) ? 8 : 4;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      slot  = SLOT_W'(e - base);
      newB  = csrWrData[{slot, 3'b000} +: 8];
      inWin = (kind == KIND_CFG) && (e >= base) && (e < base + nBytes);
      cfgNext[e*8 +: 8] = newB;
      cfgLoad[e] = csrWrEn && inWin &&
                   byteAccepted(newB, lockedNow[e], mml, rlb) &&
                   (newB != cfgArray[e*8 +: 8]);
      addrLoad[e] = csrWrEn && (kind == KIND_ADDR) && (int'(csrIdx) == e) &&
                    !lockedNow[e] && !torLockAbove[e] &&
                    (addrNext != addrArray[e*ADDR_W +: ADDR_W]);
    end
  end

  always_comb begin
    logic nMml, nMmwp, nRlb;
    nRlb  = csrWrData[SEC_RLB] && (rlb || !(|lockBit));
    nMml  = mml  | csrWrData[SEC_MML];
    nMmwp = mmwp | csrWrData[SEC_MMWP];
    if (!ENH_SEC) begin
      nRlb = 1'b0; nMml = 1'b0; nMmwp = 1'b0;
    end
    strobe.secLoad = csrWrEn && (kind == KIND_SEC);
    strobe.secNext = {nRlb, nMmwp, nMml};
    strobe.changed = (|cfgLoad) || (|addrLoad) ||
                     (strobe.secLoad && ((nMml != mml) || (nMmwp != mmwp)));
  end

endmodule

// File: rtl/mpcfg_regs.sv
module mpcfg_regs
  import mpcfg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int XLEN        = 64,
  parameter int IDX_W       = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_ENTRIES-1:0]        cfgLoad,
  input  logic [NUM_ENTRIES*8-1:0]      cfgNext,
  input  logic [NUM_ENTRIES-1:0]        addrLoad,
  input  logic [ADDR_W-1:0]             addrNext,
  input  ctrlStrobe_t                   strobe,
  input  logic [1:0]                    csrKind,
  input  logic [IDX_W-1:0]              csrIdx,
  input  logic                          csrIs64,
  output logic [NUM_ENTRIES*8-1:0]      cfgQ,
  output logic [NUM_ENTRIES*ADDR_W-1:0] addrQ,
  output logic [2:0]                    secQ,
  output logic                          pulseQ,
  output logic [XLEN-1:0]               rdData
);
  localparam int MAX_BYTES = XLEN / 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ   <= '0;
      addrQ  <= '0;
      secQ   <= '0;
      pulseQ <= 1'b0;
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (cfgLoad[e])  cfgQ[e*8 +: 8]           <= cfgNext[e*8 +: 8];
        if (addrLoad[e]) addrQ[e*ADDR_W +: ADDR_W] <= addrNext;
      end
      if (strobe.secLoad) secQ <= strobe.secNext;
      pulseQ <= strobe.changed;
    end
  end

  always_comb begin
    int base, nBytes, e;
    rdData = '0;
    base   = int'(csrIdx) * 4;
    nBytes = (csrIs64 && MAX_BYTES >= 8) ? 8 : 4;
    case (csrKind_e'(csrKind))
      KIND_CFG:
        for (int b = 0; b < MAX_BYTES; b++) begin
          e = base + b;
          if (b < nBytes && e < NUM_ENTRIES) rdData[b*8 +: 8] = cfgQ[e*8 +: 8];
        end
      KIND_ADDR:
        if (int'(csrIdx) < NUM_ENTRIES)
          rdData[ADDR_W-1:0] = addrQ[int'(csrIdx)*ADDR_W +: ADDR_W];
      KIND_SEC: rdData[2:0] = secQ;
      default: rdData = '0;
    endcase
  end

  logic anyLock;
  always_comb begin
    anyLock = 1'b0;
    for (int e = 0; e < NUM_ENTRIES; e++) anyLock |= cfgQ[e*8+BIT_L];
  end

  p_sticky_mml_r8: assert property (@(posedge clk) disable iff (rst)
    secQ[SEC_MML] |=> secQ[SEC_MML]);
  p_sticky_mmwp_r8: assert property (@(posedge clk) disable iff (rst)
    secQ[SEC_MMWP] |=> secQ[SEC_MMWP]);
  p_bypass_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (!secQ[SEC_RLB] && anyLock) |=> !secQ[SEC_RLB]);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entryChk
    p_locked_cfg_held_r4: assert property (@(posedge clk) disable iff (rst)
      (!secQ[SEC_MML] && cfgQ[g*8+BIT_L] && !secQ[SEC_RLB])
        |=> $stable(cfgQ[g*8 +: 8]));
    p_locked_addr_held_r6: assert property (@(posedge clk) disable iff (rst)
      (cfgQ[g*8+BIT_L] && !secQ[SEC_RLB]) |=> $stable(addrQ[g*ADDR_W +: ADDR_W]));
    p_no_write_only_r4: assert property (@(posedge clk) disable iff (rst)
      !secQ[SEC_MML] |-> !(cfgQ[g*8+BIT_W] && !cfgQ[g*8+BIT_R]));
  end

endmodule

// File: rtl/mpcfg_bank.sv
module mpcfg_bank
  import mpcfg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int XLEN        = 64,
  parameter int IDX_W       = 6,
  parameter bit ENH_SEC     = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          csrWrEn,
  input  logic [1:0]                    csrKind,
  input  logic [IDX_W-1:0]              csrIdx,
  input  logic [XLEN-1:0]               csrWrData,
  input  logic                          csrIs64,
  output logic [XLEN-1:0]               csrRdData,
  output logic [NUM_ENTRIES*8-1:0]      cfgArray,
  output logic [NUM_ENTRIES*ADDR_W-1:0] addrArray,
  output logic                          secMml,
  output logic                          secMmwp,
  output logic                          secRlb,
  output logic                          protChanged
);
  logic [NUM_ENTRIES-1:0]   cfgLoad, addrLoad;
  logic [NUM_ENTRIES*8-1:0] cfgNext;
  logic [ADDR_W-1:0]        addrNext;
  logic [2:0]               secQ;
  ctrlStrobe_t              strobe;

  mpcfg_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .XLEN(XLEN),
               .IDX_W(IDX_W), .ENH_SEC(ENH_SEC)) u_ctrl (
    .csrWrEn(csrWrEn), .csrKind(csrKind), .csrIdx(csrIdx),
    .csrWrData(csrWrData), .csrIs64(csrIs64),
    .cfgArray(cfgArray), .addrArray(addrArray), .secBits(secQ),
    .cfgLoad(cfgLoad), .cfgNext(cfgNext), .addrLoad(addrLoad),
    .addrNext(addrNext), .strobe(strobe));

  mpcfg_regs #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .XLEN(XLEN),
               .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .cfgNext(cfgNext),
    .addrLoad(addrLoad), .addrNext(addrNext), .strobe(strobe),
    .csrKind(csrKind), .csrIdx(csrIdx), .csrIs64(csrIs64),
    .cfgQ(cfgArray), .addrQ(addrArray), .secQ(secQ),
    .pulseQ(protChanged), .rdData(csrRdData));

  assign secMml  = secQ[SEC_MML];
  assign secMmwp = secQ[SEC_MMWP];
  assign secRlb  = secQ[SEC_RLB];

  p_pulse_needs_write_r10: assert property (@(posedge clk) disable iff (rst)
    !csrWrEn |=> !protChanged);
  p_plain_sec_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !ENH_SEC |-> (secQ == 3'b000));

endmodule

// File: tb/mpcfg_bank_tb.sv
module mpcfg_bank_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csrWrEn = 1'b0;
  logic [1:0] csrKind = 2'd3;
  logic [5:0] csrIdx = '0;
  logic [63:0] csrWrData = '0;
  logic csrIs64 = 1'b0;
  logic [63:0] csrRdData, plainRd;
  logic [127:0] cfgArray, plainCfg;
  logic [511:0] addrArray, plainAddr;
  logic secMml, secMmwp, secRlb, protChanged;
  logic pMml, pMmwp, pRlb, pChg;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mpcfg_bank u_dut (
    .clk(clk), .rst(rst), .csrWrEn(csrWrEn), .csrKind(csrKind), .csrIdx(csrIdx),
    .csrWrData(csrWrData), .csrIs64(csrIs64), .csrRdData(csrRdData),
    .cfgArray(cfgArray), .addrArray(addrArray), .secMml(secMml),
    .secMmwp(secMmwp), .secRlb(secRlb), .protChanged(protChanged));

  mpcfg_bank #(.ENH_SEC(1'b0)) u_plain (
    .clk(clk), .rst(rst), .csrWrEn(csrWrEn), .csrKind(csrKind), .csrIdx(csrIdx),
    .csrWrData(csrWrData), .csrIs64(csrIs64), .csrRdData(plainRd),
    .cfgArray(plainCfg), .addrArray(plainAddr), .secMml(pMml),
    .secMmwp(pMmwp), .secRlb(pRlb), .protChanged(pChg));

  // Behavioural reference model
  bit [7:0]  mCfg [16];
  bit [31:0] mAddr [16];
  bit mMml, mMmwp, mRlb, mPulse;

  always @(posedge clk) begin
    if (rst) begin
      foreach (mCfg[k]) begin mCfg[k] = '0; mAddr[k] = '0; end
      mMml = 0; mMmwp = 0; mRlb = 0; mPulse = 0;
    end else begin
      mPulse = 0;
      if (csrWrEn && csrKind == 2'd0) begin
        for (int i = 0; i < (csrIs64 ? 8 : 4); i++) begin
          int e;
          bit [7:0] b;
          bit ok, lk;
          e = int'(csrIdx) * 4 + i;
          b = csrWrData[8*i +: 8];
          if (e < 16) begin
            lk = mCfg[e][7] && !mRlb;
            if (!mMml) ok = !lk && !(b[1] && !b[0]);
            else ok = mRlb || (b[7] && !b[2]) || (!b[7] && b[2:0] != 3'b110);
            if (ok && b != mCfg[e]) begin mCfg[e] = b; mPulse = 1; end
          end
        end
      end else if (csrWrEn && csrKind == 2'd1 && csrIdx < 16) begin
        int n;
        bit guard;
        n = int'(csrIdx);
        guard = (n < 15) && mCfg[n+1][7] && (mCfg[n+1][4:3] == 2'd1);
        if (!guard && !(mCfg[n][7] && !mRlb) && mAddr[n] != csrWrData[31:0]) begin
          mAddr[n] = csrWrData[31:0]; mPulse = 1;
        end
      end else if (csrWrEn && csrKind == 2'd2) begin
        bit anyL, nM, nW;
        anyL = 0;
        foreach (mCfg[k]) anyL |= mCfg[k][7];
        nM = mMml | csrWrData[0];
        nW = mMmwp | csrWrData[1];
        mRlb = csrWrData[2] && (mRlb || !anyL);
        if (nM != mMml || nW != mMmwp) mPulse = 1;
        mMml = nM; mMmwp = nW;
      end
    end
  end

  // Every-clock comparison of all outputs against the model
  always @(negedge clk) begin
    if (!rst) begin
      logic [127:0] eCfg;
      logic [511:0] eAddr;
      for (int k = 0; k < 16; k++) begin
        eCfg[k*8 +: 8] = mCfg[k];
        eAddr[k*32 +: 32] = mAddr[k];
      end
      checks += 4;
      if (cfgArray !== eCfg) begin
        fails++; $display("FAIL R2 R4 R5 cfgArray act=%h exp=%h", cfgArray, eCfg);
      end
      if (addrArray !== eAddr) begin
        fails++; $display("FAIL R6 addrArray act=%h exp=%h", addrArray, eAddr);
      end
      if ({secRlb, secMmwp, secMml} !== {mRlb, mMmwp, mMml}) begin
        fails++; $display("FAIL R7 R8 sec act=%b exp=%b",
                          {secRlb, secMmwp, secMml}, {mRlb, mMmwp, mMml});
      end
      if (protChanged !== mPulse) begin
        fails++; $display("FAIL R10 protChanged act=%b exp=%b", protChanged, mPulse);
      end
    end
  end

  function automatic logic [63:0] modelRead(input logic [1:0] k, input int idx, input bit w64);
    logic [63:0] r;
    r = '0;
    if (k == 2'd0) begin
      for (int i = 0; i < (w64 ? 8 : 4); i++)
        if (idx*4 + i < 16) r[8*i +: 8] = mCfg[idx*4 + i];
    end else if (k == 2'd1) begin
      if (idx < 16) r[31:0] = mAddr[idx];
    end else if (k == 2'd2) r[2:0] = {mRlb, mMmwp, mMml};
    return r;
  endfunction

  task automatic doWrite(input logic [1:0] k, input int idx, input logic [63:0] d, input bit w64);
    @(negedge clk);
    csrKind = k; csrIdx = 6'(idx); csrWrData = d; csrIs64 = w64; csrWrEn = 1'b1;
    #1;
    checks++;
    if (csrRdData !== modelRead(k, idx, w64)) begin
      fails++; $display("FAIL R11 read during write act=%h exp=%h", csrRdData, modelRead(k, idx, w64));
    end
    @(negedge clk);
    csrWrEn = 1'b0; csrKind = 2'd3;
  endtask

  task automatic readCheck(input logic [1:0] k, input int idx, input bit w64,
                           input logic [63:0] exp, input string tag);
    @(negedge clk);
    csrKind = k; csrIdx = 6'(idx); csrIs64 = w64; csrWrEn = 1'b0;
    #1;
    checks++;
    if (csrRdData !== exp) begin
      fails++; $display("FAIL %s read act=%h exp=%h", tag, csrRdData, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    readCheck(2'd0, 0, 1, 64'h0, "R1");
    readCheck(2'd2, 0, 0, 64'h0, "R1");
    checks++;
    if (protChanged !== 1'b0) begin fails++; $display("FAIL R1 pulse act=%b exp=0", protChanged); end
    // R2: 32-bit packing, upper data ignored
    doWrite(2'd0, 0, 64'hDEAD_BEEF_1F0B_0903, 0);
    readCheck(2'd0, 0, 0, 64'h0000_0000_1F0B_0903, "R2");
    readCheck(2'd0, 1, 0, 64'h0, "R2");
    // R2: 64-bit packing, bytes past entry 15 ignored
    doWrite(2'd0, 3, 64'h8877_6655_1D19_0B05, 1);
    readCheck(2'd0, 3, 1, 64'h0000_0000_1D19_0B05, "R2");
    // R4: W-only byte dropped, no change pulse
    doWrite(2'd0, 0, 64'h1F0B_0902, 0);
    readCheck(2'd0, 0, 0, 64'h1F0B_0903, "R4");
    // R4 R10: mixed write, one byte dropped, one applied
    doWrite(2'd0, 0, 64'h1F0B_0B02, 0);
    readCheck(2'd0, 0, 0, 64'h1F0B_0B03, "R4");
    // R11: address write
    doWrite(2'd1, 4, 64'hFFFF_0000_1234_5678, 0);
    readCheck(2'd1, 4, 0, 64'h1234_5678, "R11");
    // R3: lock entry 5 in top-of-range mode
    doWrite(2'd0, 1, 64'h0000_8901, 0);
    readCheck(2'd0, 1, 0, 64'h0000_8901, "R3");
    // R6: guarded by locked TOR above, and by own lock
    doWrite(2'd1, 4, 64'hAAAA_0000, 0);
    readCheck(2'd1, 4, 0, 64'h1234_5678, "R6");
    doWrite(2'd1, 5, 64'h5555, 0);
    readCheck(2'd1, 5, 0, 64'h0, "R6");
    doWrite(2'd1, 6, 64'h66, 0);
    readCheck(2'd1, 6, 0, 64'h66, "R6");
    // R4: locked entry ignores write
    doWrite(2'd0, 1, 64'h0000_0F01, 0);
    readCheck(2'd0, 1, 0, 64'h0000_8901, "R4");
    // R7: bypass refused while a lock exists
    doWrite(2'd2, 0, 64'h4, 0);
    readCheck(2'd2, 0, 0, 64'h0, "R7");
    // R8: sticky lockdown and whitelist
    doWrite(2'd2, 0, 64'h1, 0);
    readCheck(2'd2, 0, 0, 64'h1, "R8");
    doWrite(2'd2, 0, 64'h0, 0);
    readCheck(2'd2, 0, 0, 64'h1, "R8");
    doWrite(2'd2, 0, 64'h2, 0);
    readCheck(2'd2, 0, 0, 64'h3, "R8");
    doWrite(2'd2, 0, 64'h0, 0);
    readCheck(2'd2, 0, 0, 64'h3, "R8");
    // R5: lockdown acceptance rules
    doWrite(2'd0, 1, 64'h0206_8901, 0);
    readCheck(2'd0, 1, 0, 64'h0200_8901, "R5");
    doWrite(2'd0, 1, 64'h0200_8101, 0);
    readCheck(2'd0, 1, 0, 64'h0200_8101, "R5");
    doWrite(2'd0, 1, 64'h0207_8501, 0);
    readCheck(2'd0, 1, 0, 64'h0207_8101, "R5");
    // Second phase: bypass set before any lock
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    doWrite(2'd2, 0, 64'h4, 0);
    readCheck(2'd2, 0, 0, 64'h4, "R7");
    doWrite(2'd0, 0, 64'h81, 0);
    readCheck(2'd2, 0, 0, 64'h4, "R3");
    doWrite(2'd0, 0, 64'h83, 0);
    readCheck(2'd0, 0, 0, 64'h83, "R3");
    doWrite(2'd1, 0, 64'h77, 0);
    readCheck(2'd1, 0, 0, 64'h77, "R3");
    doWrite(2'd2, 0, 64'h0, 0);
    doWrite(2'd2, 0, 64'h4, 0);
    readCheck(2'd2, 0, 0, 64'h0, "R7");
    // R9: plain build keeps security bits at zero
    doWrite(2'd2, 0, 64'h7, 0);
    readCheck(2'd2, 0, 0, 64'h3, "R8");
    checks++;
    if (plainRd !== 64'h0) begin fails++; $display("FAIL R9 plain sec act=%h exp=0", plainRd); end
    repeat (2) @(negedge clk);
    summary();
  end
endmodule